// File: doc/BRIEF.md
# Interrupt Presentation Unit

This block sits between one processor and the interrupt source layer. It keeps a 32-bit status word whose top byte is the processor's current priority threshold and whose low 24 bits name the source now waiting for service. A zero source field means nothing waits. Lower priority numbers are more favored. Beside the status word it keeps the priority of the waiting source and a software request level for inter-processor interrupts. The request level resets to 0xff, which means no request.

The source layer offers interrupts as a source number with a priority. The unit takes an offer only when it beats both the threshold and anything already waiting. A waiting source that loses its place is sent back as a reject. A refused offer is sent back on a separate bounce channel. Software acts through four strobes. An accept reads the status word and takes the waiting source. A threshold write may tighten or relax the threshold. A request-level write may raise an inter-processor interrupt, which uses reserved source number 2. An end-of-interrupt write passes the source number on to the source layer and restores the threshold. Whenever the threshold relaxes with nothing waiting, the unit asks the source layer to replay the interrupts it rejected.

Top module: `intr_present_unit`

## Requirements
- R1: On reset the status word is 0x00000000, `irq_out` is low and every notification output is low. The request level resets to 0xff and the waiting priority resets to 0xff.
- R2: With no register strobe active, an offer whose priority is numerically >= the threshold (status bits 31:24) is refused. An offer is also refused when a source is waiting whose priority is <= the offer's priority. A refused offer produces `bounce_valid` with `bounce_src` equal to the offered number, and the status word does not change.
- R3: A winning offer stores its number in status bits 23:0 and its priority as the waiting priority, and raises `irq_out`. If another source was waiting, that source's number appears on `rej_src` with `rej_valid`.
- R4: An accept (`accept_rd`) clears status bits 23:0 and drops `irq_out`. It sets the threshold to the waiting priority. The caller reads the status word in the same cycle as the strobe.
- R5: Writing a threshold lower than the current one sets the new value. If a source is waiting and the new threshold is <= that source's priority, the source is rejected, the source field clears and `irq_out` drops.
- R6: Writing a threshold >= the current one while nothing waits pulses `resend_req`. If the request level is below the new threshold, source 2 is presented at the request-level priority in the same step.
- R7: A request-level write always stores the value. When the value is below the threshold, the unit presents source 2 at that priority, rejecting any waiting source first. It does not do this if the waiting priority is already <= the value. When the value is not below the threshold, the status word does not change.
- R8: An end-of-interrupt write pulses `eoi_valid` with `eoi_src` = data bits 23:0, and sets the threshold to data bits 31:24. If nothing waits, it also performs the resend of R6 against the new threshold.
- R9: Only one register operation takes effect per cycle, in the order accept, end-of-interrupt, threshold, request level; lower-ranked strobes in that cycle are ignored. An offer in a cycle with any register strobe is bounced.
- R10: Every notification (`rej_valid`, `bounce_valid`, `resend_req`, `eoi_valid`) is a one-cycle pulse. It appears in the cycle after the operation that caused it.
- R11: `irq_out` is high exactly when status bits 23:0 are nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source layer offers an interrupt this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| accept_rd | input | 1 | Accept strobe (status read) |
| cppr_wr | input | 1 | Threshold write strobe |
| cppr_data | input | 8 | New threshold |
| mfrr_wr | input | 1 | Request-level write strobe |
| mfrr_data | input | 8 | New request level |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 32 | Threshold to restore (31:24) and finished source (23:0) |
| status_word | output | 32 | Threshold (31:24) and waiting source (23:0) |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Displaced waiting source returned |
| rej_src | output | 24 | Number of the displaced source |
| bounce_valid | output | 1 | Offer refused |
| bounce_src | output | 24 | Number of the refused offer |
| resend_req | output | 1 | Ask source layer to replay rejected interrupts |
| eoi_valid | output | 1 | End-of-interrupt notification |
| eoi_src | output | 24 | Source number that finished |

## Verification
A wrong waiting priority stays hidden in the status word. It shows up only at the next offer, threshold tightening or accept: a wrong winner or bounce, a missing reject, or a wrong threshold after accept. The bench therefore follows each state-changing step with an operation that exposes it. A stale request level shows up only when a later relaxation presents source 2, or fails to. Bad precedence shows up in the very next cycle as a missing bounce, a wrong pulse or a changed threshold.

// File: rtl/ipu_pkg.sv
`timescale 1ns/1ps
package ipu_pkg;
  localparam int PRIO_BITS = 8;
  localparam int SRC_BITS  = 24;
  localparam int WORD_BITS = PRIO_BITS + SRC_BITS;

  typedef logic [PRIO_BITS-1:0] prio_t;
  typedef logic [SRC_BITS-1:0]  src_t;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ACCEPT,
    OP_EOI,
    OP_CPPR,
    OP_MFRR
  } op_e;

  typedef struct packed {
    logic valid;
    src_t src;
  } note_t;

  // a strictly more favored than b
  function automatic logic beats(prio_t a, prio_t b);
    return a < b;
  endfunction

  // holder keeps its place against a challenger
  function automatic logic holds_off(prio_t holder, prio_t challenger);
    return holder <= challenger;
  endfunction
endpackage

// File: rtl/ipu_op_select.sv
`timescale 1ns/1ps
module ipu_op_select
  import ipu_pkg::*;
(
  input  logic accept_rd,
  input  logic eoi_wr,
  input  logic cppr_wr,
  input  logic mfrr_wr,
  input  logic offer_valid,
  output op_e  op,
  output logic offer_blocked
);
  always_comb begin
    if (accept_rd)    op = OP_ACCEPT;
    else if (eoi_wr)  op = OP_EOI;
    else if (cppr_wr) op = OP_CPPR;
    else if (mfrr_wr) op = OP_MFRR;
    else              op = OP_IDLE;
  end

  assign offer_blocked = offer_valid && (op != OP_IDLE);
endmodule

// File: rtl/ipu_offer_arb.sv
`timescale 1ns/1ps
module ipu_offer_arb
  import ipu_pkg::*;
(
  input  logic  offer_en,
  input  prio_t offer_prio,
  input  prio_t cur_cppr,
  input  src_t  pend_src,
  input  prio_t pend_prio,
  output logic  win,
  output logic  refuse,
  output logic  displace
);
  logic busy;
  assign busy     = (pend_src != '0);
  assign win      = offer_en && beats(offer_prio, cur_cppr)
                    && !(busy && holds_off(pend_prio, offer_prio));
  assign refuse   = offer_en && !win;
  assign displace = win && busy;
endmodule

// File: rtl/ipu_ipi_eval.sv
`timescale 1ns/1ps
module ipu_ipi_eval
  import ipu_pkg::*;
(
  input  logic  trig,
  input  src_t  pend_src,
  input  prio_t pend_prio,
  input  prio_t req_prio,
  output logic  take,
  output logic  displace
);
  logic busy;
  assign busy     = (pend_src != '0);
  assign take     = trig && !(busy && holds_off(pend_prio, req_prio));
  assign displace = take && busy;
endmodule

// File: rtl/intr_present_unit.sv
`timescale 1ns/1ps
module intr_present_unit
  import ipu_pkg::*;
#(
  parameter src_t IPI_SRC = src_t'(2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 offer_valid,
  input  logic [SRC_BITS-1:0]  offer_src,
  input  logic [PRIO_BITS-1:0] offer_prio,
  input  logic                 accept_rd,
  input  logic                 cppr_wr,
  input  logic [PRIO_BITS-1:0] cppr_data,
  input  logic                 mfrr_wr,
  input  logic [PRIO_BITS-1:0] mfrr_data,
  input  logic                 eoi_wr,
  input  logic [WORD_BITS-1:0] eoi_data,
  output logic [WORD_BITS-1:0] status_word,
  output logic                 irq_out,
  output logic                 rej_valid,
  output logic [SRC_BITS-1:0]  rej_src,
  output logic                 bounce_valid,
  output logic [SRC_BITS-1:0]  bounce_src,
  output logic                 resend_req,
  output logic                 eoi_valid,
  output logic [SRC_BITS-1:0]  eoi_src
);
  localparam prio_t NO_REQUEST = '1;

  // state
  prio_t cppr_q, pprio_q, mfrr_q;
  src_t  src_q;
  logic  irq_q;
  note_t rej_q, bounce_q, eoi_q;
  logic  resend_q;

  // next state
  prio_t cppr_d, pprio_d, mfrr_d;
  src_t  src_d;
  logic  irq_d;
  note_t rej_d, bounce_d, eoi_d;
  logic  resend_d;

  // named internal events
  op_e   op;
  logic  offer_blocked;
  logic  offer_win_w, offer_refuse_w, offer_disp_w;
  logic  ipi_trig_w, ipi_take_w, ipi_disp_w;
  prio_t ipi_req_w;
  prio_t eoi_cppr_w;

  assign eoi_cppr_w = eoi_data[WORD_BITS-1:SRC_BITS];

  ipu_op_select u_sel (
    .accept_rd     (accept_rd),
    .eoi_wr        (eoi_wr),
    .cppr_wr       (cppr_wr),
    .mfrr_wr       (mfrr_wr),
    .offer_valid   (offer_valid),
    .op            (op),
    .offer_blocked (offer_blocked)
  );

  ipu_offer_arb u_arb (
    .offer_en   (offer_valid && (op == OP_IDLE)),
    .offer_prio (offer_prio),
    .cur_cppr   (cppr_q),
    .pend_src   (src_q),
    .pend_prio  (pprio_q),
    .win        (offer_win_w),
    .refuse     (offer_refuse_w),
    .displace   (offer_disp_w)
  );

  // when does the inter-processor request get evaluated, and at what level
  always_comb begin
    ipi_trig_w = 1'b0;
    ipi_req_w  = mfrr_q;
    case (op)
      OP_EOI:  ipi_trig_w = (src_q == '0) && beats(mfrr_q, eoi_cppr_w);
      OP_CPPR: ipi_trig_w = !beats(cppr_data, cppr_q) && (src_q == '0)
                            && beats(mfrr_q, cppr_data);
      OP_MFRR: begin
        ipi_req_w  = mfrr_data;
        ipi_trig_w = beats(mfrr_data, cppr_q);
      end
      default: ipi_trig_w = 1'b0;
    endcase
  end

  ipu_ipi_eval u_ipi (
    .trig      (ipi_trig_w),
    .pend_src  (src_q),
    .pend_prio (pprio_q),
    .req_prio  (ipi_req_w),
    .take      (ipi_take_w),
    .displace  (ipi_disp_w)
  );

  always_comb begin
    cppr_d   = cppr_q;
    src_d    = src_q;
    pprio_d  = pprio_q;
    mfrr_d   = mfrr_q;
    irq_d    = irq_q;
    rej_d    = '0;
    eoi_d    = '0;
    resend_d = 1'b0;
    bounce_d.valid = offer_valid && (offer_blocked || offer_refuse_w);
    bounce_d.src   = offer_src;

    case (op)
      OP_ACCEPT: begin
        irq_d  = 1'b0;
        cppr_d = pprio_q;
        src_d  = '0;
      end
      OP_EOI: begin
        eoi_d.valid = 1'b1;
        eoi_d.src   = eoi_data[SRC_BITS-1:0];
        cppr_d      = eoi_cppr_w;
        if (src_q == '0) resend_d = 1'b1;
      end
      OP_CPPR: begin
        cppr_d = cppr_data;
        if (beats(cppr_data, cppr_q)) begin
          if ((src_q != '0) && holds_off(cppr_data, pprio_q)) begin
            rej_d.valid = 1'b1;
            rej_d.src   = src_q;
            src_d       = '0;
            irq_d       = 1'b0;
          end
        end else if (src_q == '0) begin
          resend_d = 1'b1;
        end
      end
      OP_MFRR: mfrr_d = mfrr_data;
      default: begin
        if (offer_win_w) begin
          if (offer_disp_w) begin
            rej_d.valid = 1'b1;
            rej_d.src   = src_q;
          end
          src_d   = offer_src;
          pprio_d = offer_prio;
          irq_d   = 1'b1;
        end
      end
    endcase

    if (ipi_take_w) begin
      if (ipi_disp_w) begin
        rej_d.valid = 1'b1;
        rej_d.src   = src_q;
      end
      src_d   = IPI_SRC;
      pprio_d = ipi_req_w;
      irq_d   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q   <= '0;
      src_q    <= '0;
      pprio_q  <= NO_REQUEST;
      mfrr_q   <= NO_REQUEST;
      irq_q    <= 1'b0;
      rej_q    <= '0;
      bounce_q <= '0;
      eoi_q    <= '0;
      resend_q <= 1'b0;
    end else begin
      cppr_q   <= cppr_d;
      src_q    <= src_d;
      pprio_q  <= pprio_d;
      mfrr_q   <= mfrr_d;
      irq_q    <= irq_d;
      rej_q    <= rej_d;
      bounce_q <= bounce_d;
      eoi_q    <= eoi_d;
      resend_q <= resend_d;
    end
  end

  assign status_word  = {cppr_q, src_q};
  assign irq_out      = irq_q;
  assign rej_valid    = rej_q.valid;
  assign rej_src      = rej_q.src;
  assign bounce_valid = bounce_q.valid;
  assign bounce_src   = bounce_q.src;
  assign resend_req   = resend_q;
  assign eoi_valid    = eoi_q.valid;
  assign eoi_src      = eoi_q.src;
endmodule

// File: rtl/ipu_checker.sv
`timescale 1ns/1ps
module ipu_checker
  import ipu_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 offer_valid,
  input logic [PRIO_BITS-1:0] offer_prio,
  input logic                 accept_rd,
  input logic                 cppr_wr,
  input logic                 mfrr_wr,
  input logic [PRIO_BITS-1:0] mfrr_data,
  input logic                 eoi_wr,
  input logic [WORD_BITS-1:0] eoi_data,
  input logic [WORD_BITS-1:0] status_word,
  input logic                 irq_out,
  input logic                 rej_valid,
  input logic [SRC_BITS-1:0]  rej_src,
  input logic                 bounce_valid,
  input logic                 eoi_valid,
  input logic [SRC_BITS-1:0]  eoi_src,
  input logic [PRIO_BITS-1:0] pend_prio
);
  logic any_op;
  assign any_op = accept_rd || eoi_wr || cppr_wr || mfrr_wr;

  // R11
  irq_tracks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (status_word[SRC_BITS-1:0] != '0));

  // R4
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_rd |=> (status_word[SRC_BITS-1:0] == '0) && !irq_out
                  && (status_word[WORD_BITS-1:SRC_BITS] == $past(pend_prio)));

  // R8
  eoi_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !accept_rd) |=> eoi_valid
      && (eoi_src == $past(eoi_data[SRC_BITS-1:0]))
      && (status_word[WORD_BITS-1:SRC_BITS] == $past(eoi_data[WORD_BITS-1:SRC_BITS])));

  // R9
  collide_bounce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && any_op) |=> bounce_valid);

  // R2
  offer_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !any_op && (offer_prio >= status_word[WORD_BITS-1:SRC_BITS]))
      |=> bounce_valid && $stable(status_word));

  // R7
  mfrr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mfrr_wr && !accept_rd && !eoi_wr && !cppr_wr
      && (mfrr_data >= status_word[WORD_BITS-1:SRC_BITS])) |=> $stable(status_word));

  // R3
  reject_named_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_src != '0));

  // R10
  eoi_pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(eoi_wr));
endmodule

bind intr_present_unit ipu_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .offer_valid  (offer_valid),
  .offer_prio   (offer_prio),
  .accept_rd    (accept_rd),
  .cppr_wr      (cppr_wr),
  .mfrr_wr      (mfrr_wr),
  .mfrr_data    (mfrr_data),
  .eoi_wr       (eoi_wr),
  .eoi_data     (eoi_data),
  .status_word  (status_word),
  .irq_out      (irq_out),
  .rej_valid    (rej_valid),
  .rej_src      (rej_src),
  .bounce_valid (bounce_valid),
  .eoi_valid    (eoi_valid),
  .eoi_src      (eoi_src),
  .pend_prio    (pprio_q)
);

// File: tb/intr_present_unit_test.sv
`timescale 1ns/1ps
module intr_present_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        accept_rd = 1'b0;
  logic        cppr_wr = 1'b0;
  logic [7:0]  cppr_data = '0;
  logic        mfrr_wr = 1'b0;
  logic [7:0]  mfrr_data = '0;
  logic        eoi_wr = 1'b0;
  logic [31:0] eoi_data = '0;
  logic [31:0] status_word;
  logic        irq_out, rej_valid, bounce_valid, resend_req, eoi_valid;
  logic [23:0] rej_src, bounce_src, eoi_src;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intr_present_unit uut (
    .clk(clk), .rst_n(rst_n),
    .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
    .accept_rd(accept_rd), .cppr_wr(cppr_wr), .cppr_data(cppr_data),
    .mfrr_wr(mfrr_wr), .mfrr_data(mfrr_data),
    .eoi_wr(eoi_wr), .eoi_data(eoi_data),
    .status_word(status_word), .irq_out(irq_out),
    .rej_valid(rej_valid), .rej_src(rej_src),
    .bounce_valid(bounce_valid), .bounce_src(bounce_src),
    .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
  );

  // op codes: 1 offer {prio,src}, 2 accept, 3 threshold, 4 request level, 5 end-of-interrupt
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] data;
    logic [3:0]  req;
    logic [31:0] st;
    logic        irq;
    logic        rej;
    logic [23:0] rsrc;
    logic        bnc;
    logic        rs;
    logic        eoi;
  } vec_t;

  localparam logic [99:0] VEC [22] = '{
    {3'd1, 32'h05000020, 4'd2, 32'h00000000, 1'b0, 1'b0, 24'h0,  1'b1, 1'b0, 1'b0},
    {3'd3, 32'h000000ff, 4'd6, 32'hff000000, 1'b0, 1'b0, 24'h0,  1'b0, 1'b1, 1'b0},
    {3'd1, 32'h05000020, 4'd3, 32'hff000020, 1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 1'b0},
    {3'd1, 32'h05000021, 4'd2, 32'hff000020, 1'b1, 1'b0, 24'h0,  1'b1, 1'b0, 1'b0},
    {3'd1, 32'h03000022, 4'd3, 32'hff000022, 1'b1, 1'b1, 24'h20, 1'b0, 1'b0, 1'b0},
    {3'd2, 32'h00000000, 4'd4, 32'h03000000, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 1'b0},
    {3'd1, 32'h02000023, 4'd3, 32'h03000023, 1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 1'b0},
    {3'd3, 32'h00000002, 4'd5, 32'h02000000, 1'b0, 1'b1, 24'h23, 1'b0, 1'b0, 1'b0},
    {3'd4, 32'h00000001, 4'd7, 32'h02000002, 1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 1'b0},
    {3'd2, 32'h00000000, 4'd4, 32'h01000000, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 1'b0},
    {3'd5, 32'hff000002, 4'd8, 32'hff000002, 1'b1, 1'b0, 24'h0,  1'b0, 1'b1, 1'b1},
    {3'd4, 32'h000000ff, 4'd7, 32'hff000002, 1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 1'b0},
    {3'd1, 32'h00000030, 4'd3, 32'hff000030, 1'b1, 1'b1, 24'h2,  1'b0, 1'b0, 1'b0},
    {3'd2, 32'h00000000, 4'd4, 32'h00000000, 1'b0, 1'b0, 24'h0,  1'b0, 1'b0, 1'b0},
    {3'd5, 32'h05000030, 4'd8, 32'h05000000, 1'b0, 1'b0, 24'h0,  1'b0, 1'b1, 1'b1},
    {3'd4, 32'h00000004, 4'd7, 32'h05000002, 1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 1'b0},
    {3'd4, 32'h00000006, 4'd7, 32'h05000002, 1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 1'b0},
    {3'd4, 32'h00000003, 4'd7, 32'h05000002, 1'b1, 1'b1, 24'h2,  1'b0, 1'b0, 1'b0},
    {3'd3, 32'h00000004, 4'd5, 32'h04000002, 1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 1'b0},
    {3'd3, 32'h00000003, 4'd5, 32'h03000000, 1'b0, 1'b1, 24'h2,  1'b0, 1'b0, 1'b0},
    {3'd3, 32'h00000007, 4'd6, 32'h07000002, 1'b1, 1'b0, 24'h0,  1'b0, 1'b1, 1'b0},
    {3'd5, 32'h07000044, 4'd8, 32'h07000002, 1'b1, 1'b0, 24'h0,  1'b0, 1'b0, 1'b1}
  };

  function automatic string rname(logic [3:0] r);
    case (r)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    offer_valid = 1'b0; accept_rd = 1'b0; cppr_wr = 1'b0;
    mfrr_wr = 1'b0; eoi_wr = 1'b0;
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] d);
    offer_valid = (op == 3'd1);
    offer_src   = d[23:0];
    offer_prio  = d[31:24];
    accept_rd   = (op == 3'd2);
    cppr_wr     = (op == 3'd3);
    cppr_data   = d[7:0];
    mfrr_wr     = (op == 3'd4);
    mfrr_data   = d[7:0];
    eoi_wr      = (op == 3'd5);
    eoi_data    = d;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic check_idle_pulses(input string req);
    check(req, "rej_valid", {31'd0, rej_valid}, 32'd0);
    check(req, "bounce_valid", {31'd0, bounce_valid}, 32'd0);
    check(req, "resend_req", {31'd0, resend_req}, 32'd0);
    check(req, "eoi_valid", {31'd0, eoi_valid}, 32'd0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "status", status_word, 32'h0);
    check("R1", "irq", {31'd0, irq_out}, 32'd0);
    check_idle_pulses("R1");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 22; i++) begin
      vec_t v;
      string rn;
      v  = vec_t'(VEC[i]);
      rn = rname(v.req);
      drive(v.op, v.data);
      check(rn, "status", status_word, v.st);
      check("R11", "irq", {31'd0, irq_out}, {31'd0, v.irq});
      check(rn, "rej_valid", {31'd0, rej_valid}, {31'd0, v.rej});
      if (v.rej) check(rn, "rej_src", {8'd0, rej_src}, {8'd0, v.rsrc});
      check(rn, "bounce_valid", {31'd0, bounce_valid}, {31'd0, v.bnc});
      if (v.bnc) check(rn, "bounce_src", {8'd0, bounce_src}, {8'd0, v.data[23:0]});
      check(rn, "resend_req", {31'd0, resend_req}, {31'd0, v.rs});
      check(rn, "eoi_valid", {31'd0, eoi_valid}, {31'd0, v.eoi});
      if (v.eoi) check(rn, "eoi_src", {8'd0, eoi_src}, {8'd0, v.data[23:0]});
    end

    // R4 accept with source 2 waiting at priority 3
    drive(3'd2, 32'h0);
    check("R4", "status", status_word, 32'h03000000);

    // R9 threshold, request level and offer together: threshold wins,
    // request level write and offer are dropped / bounced
    cppr_wr = 1'b1; cppr_data = 8'hff;
    mfrr_wr = 1'b1; mfrr_data = 8'h10;
    offer_valid = 1'b1; offer_src = 24'h50; offer_prio = 8'h01;
    @(negedge clk);
    clear_inputs();
    check("R9", "status", status_word, 32'hff000002);
    check("R9", "bounce_valid", {31'd0, bounce_valid}, 32'd1);
    check("R9", "bounce_src", {8'd0, bounce_src}, 32'h50);
    check("R9", "resend_req", {31'd0, resend_req}, 32'd1);
    check("R9", "rej_valid", {31'd0, rej_valid}, 32'd0);

    // R9 ignored request level: waiting priority is still 3, so priority 5 is refused
    drive(3'd1, 32'h05000051);
    check("R9", "bounce_valid", {31'd0, bounce_valid}, 32'd1);
    check("R9", "status", status_word, 32'hff000002);

    // R10 pulses last one cycle
    @(negedge clk);
    check_idle_pulses("R10");
    check("R10", "status", status_word, 32'hff000002);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "status", status_word, 32'h0);
    check("R1", "irq", {31'd0, irq_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule